// File: doc/BRIEF.md
# Energy Window Pixel Flagger

The flagger sits in a pixel processing pipeline after offset and common-mode correction. Each incoming sample carries a corrected energy and the line and column of its pixel. The block compares the energy against a programmable lower and upper bound and appends a 5-bit flag field to the sample. The flags mark the sample as one of three kinds: inside the energy window, above it (a direct particle hit that must not count as an event), or below it (noise).

A fourth flag marks a valid pixel whose left neighbour, the previous column of the same line, was also valid. It is a cheap hint that a photon's charge was split across pixels. Classification of patterns across lines is left to later stages.

Thresholds are written through a small register port into staging registers. They are copied into the working comparators only when a frame-start pulse arrives, so a frame is always judged against one consistent pair of bounds.

Top module: `evf_flagger`

## Requirements
- R1: A sample accepted with `pix_valid_i` high appears one clock later with `out_valid_o` high, carrying unchanged energy, line and column; with no input sample, `out_valid_o` is low in the next cycle.
- R2: Flag bit 0 (in-window) is set exactly when lower <= energy <= upper, with both bounds inclusive.
- R3: Flag bit 1 (over-range hit) is set exactly when energy > upper, and such a sample never has bit 0 set.
- R4: Flag bit 2 (under-threshold) is set exactly when energy < lower.
- R5: Flag bit 3 (left neighbour) is set when the sample is in-window and the previous accepted sample was in-window, on the same line, at column one less.
- R6: Bit 3 is never set at column 0, across a line change, across a column gap, or for the first sample after a frame-start pulse.
- R7: A configuration write (`cfg_sel_i` 0 = lower bound, 1 = upper bound) changes no flag until the next `frame_start_i` pulse; a sample presented in the same cycle as that pulse already uses the new bounds.
- R8: After reset, the output is idle with flags zero, the bounds are lower = 0 and upper = all ones, and flag bit 4 is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_start_i | input | 1 | One-cycle pulse marking a new frame; loads staged bounds |
| cfg_we_i | input | 1 | Bound write strobe |
| cfg_sel_i | input | 1 | Bound select: 0 lower, 1 upper |
| cfg_data_i | input | EW | Bound value |
| pix_valid_i | input | 1 | Input sample present |
| pix_energy_i | input | EW | Corrected energy |
| pix_line_i | input | LW | Line coordinate |
| pix_col_i | input | CW | Column coordinate |
| out_valid_o | output | 1 | Output sample present |
| out_energy_o | output | EW | Energy, passed through |
| out_line_o | output | LW | Line, passed through |
| out_col_o | output | CW | Column, passed through |
| out_flags_o | output | 5 | Flags: bit0 in-window, bit1 over, bit2 under, bit3 left neighbour, bit4 zero |

## Verification
The bench builds the flagger with an 8-bit energy and 3-bit line and column fields. With those widths the all-ones energy, the last column and line wrap are reached in a few samples. Bounds are placed so that each of them and the values one step on either side can be driven directly, which exercises the inclusive edges. Short runs along a line, with a column gap, a line change and a frame pulse between them, cover each way the left-neighbour flag must clear.

// File: rtl/evf_pkg.sv
package evf_pkg;
  localparam int unsigned FLAG_W   = 5;
  localparam int unsigned F_INWIN  = 0;
  localparam int unsigned F_OVER   = 1;
  localparam int unsigned F_UNDER  = 2;
  localparam int unsigned F_LEFT   = 3;
  localparam int unsigned F_RSVD   = 4;

  typedef enum logic {
    SEL_LOWER = 1'b0,
    SEL_UPPER = 1'b1
  } bound_sel_e;
endpackage

// File: rtl/evf_bounds.sv
module evf_bounds #(
  parameter int unsigned EW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_start_i,
  input  logic          cfg_we_i,
  input  logic          cfg_sel_i,
  input  logic [EW-1:0] cfg_data_i,
  output logic [EW-1:0] lo_o,
  output logic [EW-1:0] hi_o
);
  import evf_pkg::*;

  localparam logic [EW-1:0] LO_RST = '0;
  localparam logic [EW-1:0] HI_RST = '1;

  logic [EW-1:0] stg_lo, stg_hi, act_lo, act_hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_lo <= LO_RST;
      stg_hi <= HI_RST;
    end else if (cfg_we_i) begin
      if (bound_sel_e'(cfg_sel_i) == SEL_UPPER) stg_hi <= cfg_data_i;
      else                                       stg_lo <= cfg_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_lo <= LO_RST;
      act_hi <= HI_RST;
    end else if (frame_start_i) begin
      act_lo <= stg_lo;
      act_hi <= stg_hi;
    end
  end

  // the frame-start cycle already sees the staged bounds
  assign lo_o = frame_start_i ? stg_lo : act_lo;
  assign hi_o = frame_start_i ? stg_hi : act_hi;

  a_r7_bounds_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(frame_start_i) |-> ($stable(act_lo) && $stable(act_hi)));
endmodule

// File: rtl/evf_classify.sv
module evf_classify #(
  parameter int unsigned EW = 14
) (
  input  logic [EW-1:0] energy_i,
  input  logic [EW-1:0] lo_i,
  input  logic [EW-1:0] hi_i,
  output logic          inwin_o,
  output logic          over_o,
  output logic          under_o
);
  always_comb begin
    over_o  = energy_i > hi_i;
    under_o = energy_i < lo_i;
    inwin_o = !over_o && !under_o;
  end
endmodule

// File: rtl/evf_neighbour.sv
module evf_neighbour #(
  parameter int unsigned LW = 9,
  parameter int unsigned CW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_start_i,
  input  logic          pix_valid_i,
  input  logic          inwin_i,
  input  logic [LW-1:0] line_i,
  input  logic [CW-1:0] col_i,
  output logic          left_o
);
  logic          prev_ok;
  logic [LW-1:0] prev_line;
  logic [CW-1:0] prev_col;
  logic          prev_live;

  assign prev_live = prev_ok && !frame_start_i;

  always_comb begin
    left_o = inwin_i && prev_live && (col_i != '0)
          && (prev_line == line_i) && (prev_col == col_i - CW'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_ok   <= 1'b0;
      prev_line <= '0;
      prev_col  <= '0;
    end else if (pix_valid_i) begin
      prev_ok   <= inwin_i;
      prev_line <= line_i;
      prev_col  <= col_i;
    end else if (frame_start_i) begin
      prev_ok   <= 1'b0;
    end
  end

  a_r6_frame_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |-> !left_o);
endmodule

// File: rtl/evf_flagger.sv
module evf_flagger
  import evf_pkg::*;
#(
  parameter int unsigned EW = 14,
  parameter int unsigned LW = 9,
  parameter int unsigned CW = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic [EW-1:0]     cfg_data_i,
  input  logic              pix_valid_i,
  input  logic [EW-1:0]     pix_energy_i,
  input  logic [LW-1:0]     pix_line_i,
  input  logic [CW-1:0]     pix_col_i,
  output logic              out_valid_o,
  output logic [EW-1:0]     out_energy_o,
  output logic [LW-1:0]     out_line_o,
  output logic [CW-1:0]     out_col_o,
  output logic [FLAG_W-1:0] out_flags_o
);
  logic [EW-1:0]     lo, hi;
  logic              inwin, over, under, left;
  logic [FLAG_W-1:0] flags_d;

  evf_bounds #(.EW(EW)) u_bounds (
    .clk_i, .rst_ni, .frame_start_i, .cfg_we_i, .cfg_sel_i, .cfg_data_i,
    .lo_o(lo), .hi_o(hi)
  );

  evf_classify #(.EW(EW)) u_classify (
    .energy_i(pix_energy_i), .lo_i(lo), .hi_i(hi),
    .inwin_o(inwin), .over_o(over), .under_o(under)
  );

  evf_neighbour #(.LW(LW), .CW(CW)) u_neighbour (
    .clk_i, .rst_ni, .frame_start_i, .pix_valid_i,
    .inwin_i(inwin), .line_i(pix_line_i), .col_i(pix_col_i), .left_o(left)
  );

  always_comb begin
    flags_d          = '0;
    flags_d[F_INWIN] = inwin;
    flags_d[F_OVER]  = over;
    flags_d[F_UNDER] = under;
    flags_d[F_LEFT]  = left;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o  <= 1'b0;
      out_energy_o <= '0;
      out_line_o   <= '0;
      out_col_o    <= '0;
      out_flags_o  <= '0;
    end else begin
      out_valid_o <= pix_valid_i;
      if (pix_valid_i) begin
        out_energy_o <= pix_energy_i;
        out_line_o   <= pix_line_i;
        out_col_o    <= pix_col_i;
        out_flags_o  <= flags_d;
      end
    end
  end

  a_r1_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_i |=> (out_valid_o && out_energy_o == $past(pix_energy_i)));
  a_r3_over_not_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !(out_flags_o[F_OVER] && out_flags_o[F_INWIN]));
  a_r5_left_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_flags_o[F_LEFT]) |-> out_flags_o[F_INWIN]);
  a_r6_col0_no_left: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_col_o == '0) |-> !out_flags_o[F_LEFT]);
endmodule

// File: tb/test_evf_flagger.sv
`timescale 1ns/100ps
module test_evf_flagger;
  localparam int unsigned EW = 8;
  localparam int unsigned LW = 3;
  localparam int unsigned CW = 3;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          frame_start_i = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic          cfg_sel_i = 1'b0;
  logic [EW-1:0] cfg_data_i = '0;
  logic          pix_valid_i = 1'b0;
  logic [EW-1:0] pix_energy_i = '0;
  logic [LW-1:0] pix_line_i = '0;
  logic [CW-1:0] pix_col_i = '0;
  logic          out_valid_o;
  logic [EW-1:0] out_energy_o;
  logic [LW-1:0] out_line_o;
  logic [CW-1:0] out_col_o;
  logic [4:0]    out_flags_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  evf_flagger #(.EW(EW), .LW(LW), .CW(CW)) i_evf_flagger (
    .clk_i(clk), .rst_ni, .frame_start_i, .cfg_we_i, .cfg_sel_i, .cfg_data_i,
    .pix_valid_i, .pix_energy_i, .pix_line_i, .pix_col_i,
    .out_valid_o, .out_energy_o, .out_line_o, .out_col_o, .out_flags_o
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one sample at a negedge, check the registered result one clock later
  task automatic send(string req, int e, int l, int c, logic [4:0] exp_f,
                      bit fs = 1'b0);
    pix_valid_i   = 1'b1;
    pix_energy_i  = EW'(e);
    pix_line_i    = LW'(l);
    pix_col_i     = CW'(c);
    frame_start_i = fs;
    @(negedge clk);
    frame_start_i = 1'b0;
    check({req, " flags"}, 32'(out_flags_o), 32'(exp_f));
    check({req, " valid"}, 32'(out_valid_o), 32'd1);
    check({req, " pass"}, {8'h0, out_energy_o, 5'(out_line_o), 5'(out_col_o)},
          {8'h0, EW'(e), 5'(l), 5'(c)});
  endtask

  task automatic idle();
    pix_valid_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_bound(bit sel, int v);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_data_i = EW'(v);
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic pulse_frame();
    frame_start_i = 1'b1;
    @(negedge clk);
    frame_start_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R8 reset idle", 32'(out_valid_o), 0);
    check("R8 reset flags", 32'(out_flags_o), 0);
    send("R8 default upper", 255, 0, 0, 5'b00001);
    send("R8 default lower", 0, 0, 2, 5'b00001);
    idle();
    check("R1 idle follows", 32'(out_valid_o), 0);
  endtask

  task automatic t_staging();
    write_bound(1'b0, 20);
    write_bound(1'b1, 200);
    send("R7 staged not live low", 10, 1, 0, 5'b00001);
    send("R7 staged not live high", 250, 1, 2, 5'b00001);
    idle();
    // new bounds apply to a sample in the pulse cycle
    send("R7 pulse cycle uses new", 10, 2, 0, 5'b00100, 1'b1);
    idle();
  endtask

  task automatic t_window();
    send("R2 lower edge", 20, 3, 0, 5'b00001);
    send("R4 below lower", 19, 3, 2, 5'b00100);
    send("R2 upper edge", 200, 3, 4, 5'b00001);
    send("R3 above upper", 201, 3, 6, 5'b00010);
    send("R3 max energy", 255, 4, 0, 5'b00010);
    send("R4 zero energy", 0, 4, 2, 5'b00100);
    idle();
  endtask

  task automatic t_neighbour();
    send("R6 col0 first", 50, 5, 0, 5'b00001);
    send("R5 col1 after valid", 60, 5, 1, 5'b01001);
    send("R3 col2 over", 240, 5, 2, 5'b00010);
    send("R5 col3 after over", 60, 5, 3, 5'b00001);
    send("R5 col4 chain", 70, 5, 4, 5'b01001);
    send("R6 gap col6", 70, 5, 6, 5'b00001);
    send("R5 last col", 80, 5, 7, 5'b01001);
    send("R6 line wrap col0", 80, 6, 0, 5'b00001);
    send("R6 line change", 80, 7, 1, 5'b00001);
    send("R5 next", 90, 7, 2, 5'b01001);
    idle();
    pulse_frame();
    send("R6 after frame", 90, 7, 3, 5'b00001);
    send("R5 after frame chain", 90, 7, 4, 5'b01001);
    send("R6 frame in-cycle", 90, 7, 5, 5'b00001, 1'b1);
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_staging();
    t_window();
    t_neighbour();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule